// File: doc/BRIEF.md
# I2C Target Register-Access Interface

This block lets an I2C bus master reach a small file of byte-wide registers. It samples the SCL and SDA lines with a fast system clock and drives SDA only as an open-drain pull-down through an output-enable signal. It recognises START, repeated START and STOP conditions and answers a single fixed 7-bit address. The first byte written after the address is a command byte that sets an internal register pointer. Further written bytes go into the pointed register, and reads shift out the pointed register. In both directions the pointer steps forward through the file and wraps at the end.

A read is done in two parts. The master first writes the command byte, then issues a repeated START with the same address and the read bit set, and clocks data out. Each byte the master acknowledges moves the pointer to the next register. A not-acknowledge ends the read. Other logic on the chip reaches the same registers through a plain parallel port with a one-cycle read latency. The register count must be a power of two, and the system clock must run at least eight times faster than SCL.

Top module: `i2c_regtarget`

## Requirements
- R1: After reset the target leaves SDA released (`sda_oe` = 0) and stays passive until a START is seen.
- R2: An address byte whose upper seven bits equal 1100100 (byte 0xC8 for write, 0xC9 for read) is acknowledged by pulling SDA low in the ninth clock. Any other address is not acknowledged, and until the next START or STOP no later byte is acknowledged and no register changes.
- R3: In a write, the byte after the address is a command byte. It is acknowledged, and its low log2(REG_COUNT) bits (bits 2..0 for 8 registers) load the register pointer. Its upper bits are ignored.
- R4: Each written byte after the command byte is acknowledged and stored in the register the pointer selects, and the pointer then advances by one. It wraps from register REG_COUNT-1 to register 0.
- R5: After a repeated START, an address byte with R/W = 1 is acknowledged. The target then shifts out the pointed register, MSB first, one bit per SCL clock.
- R6: During a read, a master ACK advances the pointer and the next register is sent, with the same wrap. A master NAK makes the target keep SDA released for all further clocks until the next START.
- R7: The target changes its SDA drive only while SCL is low.
- R8: A repeated START behaves exactly like a START. Address reception restarts, including after an unmatched address or in the middle of a write.
- R9: A STOP at any point, including in the middle of a byte, returns the target to idle. A byte that was not completed is not stored, and registers written earlier keep their values.
- R10: The parallel port writes a register at the clock edge where `host_we` is high. It returns the register named by `host_addr` on `host_rdata` one cycle later. Bytes written by either side are visible to the other side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level from the pad |
| sda_i | input | 1 | SDA line level from the pad |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| host_we | input | 1 | Parallel-port write strobe |
| host_addr | input | log2(REG_COUNT) | Parallel-port register index |
| host_wdata | input | 8 | Parallel-port write data |
| host_rdata | output | 8 | Parallel-port read data, one cycle after `host_addr` |

## Verification
The hardest situation to reach from the ports is a transfer cut short: a STOP after only part of a data byte, or a repeated START that arrives after an unmatched address. In both cases the target must drop what it was doing and commit nothing. The bench drives the bus at bit level, so it can emit four data bits and then a STOP. It can also follow a NAKed address straight with a repeated START. Afterwards it reads the registers through the parallel port to confirm that nothing was disturbed.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = $clog2(BYTE_W + 1);

  typedef enum logic [2:0] {
    BS_IDLE,
    BS_RX,
    BS_RX_ACK,
    BS_TX,
    BS_TX_ACK
  } bus_state_t;

  typedef enum logic [1:0] {
    PH_ADDR,
    PH_CMD,
    PH_DATA
  } rx_phase_t;
endpackage

// File: rtl/i2ct_line_sync.sv
module i2ct_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [SYNC_STAGES-1:0] scl_ch;
  logic [SYNC_STAGES-1:0] sda_ch;
  logic scl_q;
  logic sda_q;

  // idle bus is high on both lines, so reset the chains to ones
  always_ff @(posedge clk) begin
    if (rst) begin
      scl_ch <= '1;
      sda_ch <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ch <= {scl_ch[SYNC_STAGES-2:0], scl_i};
      sda_ch <= {sda_ch[SYNC_STAGES-2:0], sda_i};
      scl_q  <= scl_ch[SYNC_STAGES-1];
      sda_q  <= sda_ch[SYNC_STAGES-1];
    end
  end

  assign scl_s     = scl_ch[SYNC_STAGES-1];
  assign sda_s     = sda_ch[SYNC_STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2ct_regfile.sv
module i2ct_regfile #(
  parameter int REG_COUNT = 8,
  parameter int DATA_W    = 8,
  localparam int AW       = $clog2(REG_COUNT)
) (
  input  logic              clk,
  input  logic              a_we,
  input  logic [AW-1:0]     a_waddr,
  input  logic [DATA_W-1:0] a_wdata,
  input  logic [AW-1:0]     a_raddr,
  output logic [DATA_W-1:0] a_rdata,
  input  logic              b_we,
  input  logic [AW-1:0]     b_addr,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata
);
  logic [DATA_W-1:0] mem [REG_COUNT];

  // single write process; the bus side wins a same-cycle collision
  always_ff @(posedge clk) begin
    if (a_we) begin
      mem[a_waddr] <= a_wdata;
    end else if (b_we) begin
      mem[b_addr] <= b_wdata;
    end
  end

  always_ff @(posedge clk) begin
    a_rdata <= mem[a_raddr];
    b_rdata <= mem[b_addr];
  end
endmodule

// File: rtl/i2ct_target_fsm.sv
module i2ct_target_fsm
  import i2ct_pkg::*;
#(
  parameter int           PTR_W    = 3,
  parameter logic [6:0]   DEV_ADDR = 7'b1100100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_evt,
  input  logic              stop_evt,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              sda_oe,
  output logic              wr_en,
  output logic [PTR_W-1:0]  wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic [PTR_W-1:0]  ptr,
  output logic              busy
);
  localparam logic [CNT_W-1:0] RX_FULL = CNT_W'(BYTE_W);
  localparam logic [CNT_W-1:0] TX_LAST = CNT_W'(BYTE_W - 1);

  bus_state_t        state;
  rx_phase_t         phase;
  logic [CNT_W-1:0]  bit_cnt;
  logic [BYTE_W-1:0] rx_sr;
  logic [BYTE_W-1:0] tx_sr;
  logic              rw;
  logic              mst_ack;

  assign busy = (state != BS_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= BS_IDLE;
      phase   <= PH_ADDR;
      bit_cnt <= '0;
      rx_sr   <= '0;
      tx_sr   <= '0;
      rw      <= 1'b0;
      mst_ack <= 1'b0;
      ptr     <= '0;
      sda_oe  <= 1'b0;
      wr_en   <= 1'b0;
      wr_addr <= '0;
      wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (start_evt) begin
        state   <= BS_RX;
        phase   <= PH_ADDR;
        bit_cnt <= '0;
        sda_oe  <= 1'b0;
      end else if (stop_evt) begin
        state  <= BS_IDLE;
        sda_oe <= 1'b0;
      end else begin
        unique case (state)
          BS_RX: begin
            if (scl_rise) begin
              rx_sr   <= {rx_sr[BYTE_W-2:0], sda_s};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_fall && bit_cnt == RX_FULL) begin
              bit_cnt <= '0;
              unique case (phase)
                PH_ADDR: begin
                  if (rx_sr[BYTE_W-1:1] == DEV_ADDR) begin
                    sda_oe <= 1'b1;
                    rw     <= rx_sr[0];
                    state  <= BS_RX_ACK;
                  end else begin
                    state <= BS_IDLE;
                  end
                end
                PH_CMD: begin
                  sda_oe <= 1'b1;
                  ptr    <= rx_sr[PTR_W-1:0];
                  state  <= BS_RX_ACK;
                end
                default: begin
                  sda_oe  <= 1'b1;
                  wr_en   <= 1'b1;
                  wr_addr <= ptr;
                  wr_data <= rx_sr;
                  ptr     <= ptr + 1'b1;
                  state   <= BS_RX_ACK;
                end
              endcase
            end
          end
          BS_RX_ACK: begin
            if (scl_fall) begin
              if (phase == PH_ADDR && rw) begin
                state   <= BS_TX;
                tx_sr   <= rd_data;
                sda_oe  <= ~rd_data[BYTE_W-1];
                bit_cnt <= '0;
              end else begin
                sda_oe <= 1'b0;
                state  <= BS_RX;
                phase  <= (phase == PH_ADDR) ? PH_CMD : PH_DATA;
              end
            end
          end
          BS_TX: begin
            if (scl_fall) begin
              if (bit_cnt == TX_LAST) begin
                sda_oe  <= 1'b0;
                bit_cnt <= '0;
                state   <= BS_TX_ACK;
              end else begin
                bit_cnt <= bit_cnt + 1'b1;
                tx_sr   <= {tx_sr[BYTE_W-2:0], 1'b0};
                sda_oe  <= ~tx_sr[BYTE_W-2];
              end
            end
          end
          BS_TX_ACK: begin
            if (scl_rise) begin
              mst_ack <= ~sda_s;
              if (!sda_s) ptr <= ptr + 1'b1;
            end else if (scl_fall) begin
              if (mst_ack) begin
                state   <= BS_TX;
                tx_sr   <= rd_data;
                sda_oe  <= ~rd_data[BYTE_W-1];
                bit_cnt <= '0;
              end else begin
                state <= BS_IDLE;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_regtarget.sv
module i2c_regtarget
  import i2ct_pkg::*;
#(
  parameter int         REG_COUNT   = 8,
  parameter int         SYNC_STAGES = 2,
  parameter logic [6:0] DEV_ADDR    = 7'b1100100,
  localparam int        PTR_W       = $clog2(REG_COUNT)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_oe,
  input  logic              host_we,
  input  logic [PTR_W-1:0]  host_addr,
  input  logic [BYTE_W-1:0] host_wdata,
  output logic [BYTE_W-1:0] host_rdata
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic bus_we, busy;
  logic [PTR_W-1:0]  bus_waddr, ptr;
  logic [BYTE_W-1:0] bus_wdata, bus_rdata;

  i2ct_line_sync #(.SYNC_STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  i2ct_target_fsm #(.PTR_W(PTR_W), .DEV_ADDR(DEV_ADDR)) fsm_i (
    .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt), .rd_data(bus_rdata),
    .sda_oe(sda_oe), .wr_en(bus_we), .wr_addr(bus_waddr), .wr_data(bus_wdata),
    .ptr(ptr), .busy(busy)
  );

  i2ct_regfile #(.REG_COUNT(REG_COUNT), .DATA_W(BYTE_W)) regs_i (
    .clk(clk),
    .a_we(bus_we), .a_waddr(bus_waddr), .a_wdata(bus_wdata),
    .a_raddr(ptr), .a_rdata(bus_rdata),
    .b_we(host_we), .b_addr(host_addr), .b_wdata(host_wdata), .b_rdata(host_rdata)
  );
endmodule

// File: rtl/i2ct_checker.sv
module i2ct_checker (
  input logic clk,
  input logic rst,
  input logic scl_s,
  input logic sda_oe,
  input logic start_evt,
  input logic stop_evt,
  input logic bus_we,
  input logic busy
);
  // R7: drive changes only with SCL low
  assert_oe_scl_low_R7: assert property (@(posedge clk) disable iff (rst)
    !$stable(sda_oe) |-> !scl_s);

  // R8: any START condition releases the line
  assert_start_release_R8: assert property (@(posedge clk) disable iff (rst)
    start_evt |=> !sda_oe);

  // R9: STOP returns to idle with the line released
  assert_stop_idle_R9: assert property (@(posedge clk) disable iff (rst)
    stop_evt |=> (!busy && !sda_oe));

  // R4: a stored byte is acknowledged
  assert_store_ack_R4: assert property (@(posedge clk) disable iff (rst)
    bus_we |-> sda_oe);

  // R1: never drive while idle
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
    sda_oe |-> busy);
endmodule

bind i2c_regtarget i2ct_checker chk_i (
  .clk(clk), .rst(rst), .scl_s(scl_s), .sda_oe(sda_oe),
  .start_evt(start_evt), .stop_evt(stop_evt), .bus_we(bus_we), .busy(busy)
);

// File: tb/i2c_regtarget_tb_top.sv
module i2c_regtarget_tb_top;
  localparam int Q = 10;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic       sda_oe;
  logic       host_we = 1'b0;
  logic [2:0] host_addr = '0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic       sda_line;
  logic [7:0] mdl [8];
  int total = 0;
  int bad = 0;
  int viol = 0;
  logic prev_oe = 1'b0;

  always #10 clk = ~clk;
  assign sda_line = sda_m & ~sda_oe;

  i2c_regtarget dut_i (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .host_we(host_we), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_rdata(host_rdata)
  );

  // R7 monitor: drive must not change while the master holds SCL high
  always @(negedge clk) begin
    if (!rst && scl_m && (sda_oe != prev_oe)) viol++;
    prev_oe = sda_oe;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic qw();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; qw(); scl_m = 1'b1; qw(); sda_m = 1'b0; qw(); scl_m = 1'b0; qw();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; qw(); scl_m = 1'b1; qw(); sda_m = 1'b1; qw();
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; qw(); scl_m = 1'b1; qw(); qw(); scl_m = 1'b0; qw();
    end
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    send_bits(b, 8);
    sda_m = 1'b1; qw(); scl_m = 1'b1; qw();
    ack = !sda_line;
    qw(); scl_m = 1'b0; qw();
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      qw(); scl_m = 1'b1; qw(); b[i] = sda_line; qw(); scl_m = 1'b0;
    end
    qw(); sda_m = give_ack ? 1'b0 : 1'b1; qw(); scl_m = 1'b1; qw(); qw();
    scl_m = 1'b0; qw(); sda_m = 1'b1;
  endtask

  task automatic host_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); host_we = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk); host_we = 1'b0;
    mdl[a] = d;
  endtask

  task automatic host_check(input logic [2:0] a, input string tag);
    @(negedge clk); host_addr = a;
    @(negedge clk);
    check(host_rdata == mdl[a], tag, host_rdata, mdl[a]);
  endtask

  task automatic bus_write(input logic [7:0] cmd, input logic [7:0] d, input string tag);
    bit ack;
    bus_start();
    send_byte(8'hC8, ack); check(ack, tag, ack, 1);
    send_byte(cmd, ack);   check(ack, tag, ack, 1);
    send_byte(d, ack);     check(ack, tag, ack, 1);
    bus_stop();
    mdl[cmd[2:0]] = d;
  endtask

  task automatic t_reset_init();
    check(sda_oe == 1'b0, "R1 released after reset", sda_oe, 0);
    for (int i = 0; i < 8; i++) host_write(3'(i), 8'hA0 + 8'(i));
    host_check(3'd3, "R10 host readback reg3");
    host_check(3'd7, "R10 host readback reg7");
  endtask

  task automatic t_bad_address();
    bit ack;
    bus_start();
    send_byte(8'hCA, ack); check(!ack, "R2 wrong address NAK", ack, 0);
    send_byte(8'h03, ack); check(!ack, "R2 ignored byte after mismatch", ack, 0);
    send_byte(8'h99, ack); check(!ack, "R2 ignored data after mismatch", ack, 0);
    bus_stop();
    host_check(3'd3, "R2 register untouched after mismatch");
  endtask

  task automatic t_write_burst();
    bit ack;
    bus_start();
    send_byte(8'hC8, ack); check(ack, "R2 matching address ACK", ack, 1);
    send_byte(8'hFE, ack); check(ack, "R3 command byte ACK", ack, 1);
    send_byte(8'h11, ack); check(ack, "R4 data ACK 0", ack, 1);
    send_byte(8'h22, ack); check(ack, "R4 data ACK 1", ack, 1);
    send_byte(8'h33, ack); check(ack, "R4 data ACK 2", ack, 1);
    bus_stop();
    mdl[6] = 8'h11; mdl[7] = 8'h22; mdl[0] = 8'h33;
    host_check(3'd6, "R3 pointer from low bits, reg6");
    host_check(3'd7, "R4 pointer advance, reg7");
    host_check(3'd0, "R4 pointer wrap, reg0");
    host_check(3'd1, "R4 reg1 untouched");
  endtask

  task automatic t_read_burst();
    bit ack;
    logic [7:0] d;
    int lows = 0;
    bus_start();
    send_byte(8'hC8, ack); check(ack, "R5 write address ACK", ack, 1);
    send_byte(8'h05, ack); check(ack, "R5 command ACK", ack, 1);
    bus_start();
    send_byte(8'hC9, ack); check(ack, "R5 read address ACK", ack, 1);
    recv_byte(1'b1, d); check(d == mdl[5], "R5 first read byte", d, mdl[5]);
    recv_byte(1'b1, d); check(d == mdl[6], "R6 ACK advances", d, mdl[6]);
    recv_byte(1'b1, d); check(d == mdl[7], "R6 ACK advances again", d, mdl[7]);
    recv_byte(1'b0, d); check(d == mdl[0], "R6 pointer wrap on read", d, mdl[0]);
    // after NAK the line must stay released for further clocks
    for (int i = 0; i < 9; i++) begin
      qw(); scl_m = 1'b1; qw();
      if (!sda_line) lows++;
      qw(); scl_m = 1'b0; qw();
    end
    check(lows == 0, "R6 released after NAK", lows, 0);
    bus_stop();
  endtask

  task automatic t_stop_midbyte();
    bit ack;
    bus_start();
    send_byte(8'hC8, ack); check(ack, "R9 address ACK", ack, 1);
    send_byte(8'h02, ack); check(ack, "R9 command ACK", ack, 1);
    send_bits(8'hB5, 4);
    bus_stop();
    host_check(3'd2, "R9 partial byte not stored");
    host_check(3'd6, "R9 earlier write kept");
    bus_write(8'h02, 8'h5A, "R9 transfer after STOP");
    host_check(3'd2, "R9 write after partial STOP");
  endtask

  task automatic t_repeated_start();
    bit ack;
    bus_start();
    send_byte(8'hC8, ack); send_byte(8'h01, ack); send_byte(8'h44, ack);
    bus_start();
    send_byte(8'hC8, ack); check(ack, "R8 address after Sr ACK", ack, 1);
    send_byte(8'h04, ack); send_byte(8'h55, ack);
    bus_stop();
    mdl[1] = 8'h44; mdl[4] = 8'h55;
    host_check(3'd1, "R8 byte before Sr stored");
    host_check(3'd4, "R8 new pointer after Sr");
    bus_start();
    send_byte(8'hCA, ack); check(!ack, "R8 mismatch before Sr", ack, 0);
    bus_start();
    send_byte(8'hC8, ack); check(ack, "R8 Sr recovers after mismatch", ack, 1);
    send_byte(8'h03, ack); send_byte(8'h66, ack);
    bus_stop();
    mdl[3] = 8'h66;
    host_check(3'd3, "R8 write after recovery");
  endtask

  task automatic t_host_to_bus();
    bit ack;
    logic [7:0] d;
    host_write(3'd7, 8'h7E);
    bus_start();
    send_byte(8'hC8, ack); send_byte(8'h07, ack);
    bus_start();
    send_byte(8'hC9, ack);
    recv_byte(1'b0, d);
    bus_stop();
    check(d == 8'h7E, "R10 host write visible on bus", d, 8'h7E);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);
    t_reset_init();
    t_bad_address();
    t_write_burst();
    t_read_burst();
    t_stop_midbyte();
    t_repeated_start();
    t_host_to_bus();
    check(viol == 0, "R7 drive changed with SCL high", viol, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule